// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of general-purpose I/O with thirty-two pins, sitting behind a plain word-addressed register port. Software reads the pad levels through a two-flop synchroniser. It drives each pad from a data bit when that pad's output enable is set. It also sets a pull resistor direction and a three-bit drive-strength code for every pin. These settings leave the block on plain pad-control pins, so an external pad ring can use them.

Every pin can latch an interrupt event into a sticky status bit. Three per-pin bits choose the trigger. One picks level or edge sensing. One allows both edges. One picks rising/active-high or falling/active-low. Software masks pins, reads the raw and masked status, and clears events by writing ones. The bank raises one registered interrupt line whenever any unmasked status bit is set.

The register port is a control path and carries no stream. Writes complete in the cycle `wr_en` is high. Read data is a combinational function of `addr`. Neither direction ever stalls, so the port has no valid/ready pair and no back-pressure.

Top module: `gib_bank`

## Requirements
- R1: After reset, every register reads zero. `pad_oe`, `pad_out`, `pad_pull_en`, `pad_pull_up`, `pad_drive` and `irq` are all zero.
- R2: Offset 0x04 holds the data-out word and offset 0x08 holds the output-enable word. Both read back as written. Bit n of each drives `pad_out[n]` and `pad_oe[n]` directly.
- R3: Offset 0x00 is read-only and shows the pad levels. A change on `pad_in` is visible there after the second rising clock edge. Writes to offset 0x00 change nothing.
- R4: Offset 0x38 is the pull-enable word and offset 0x34 is the pull-select word. They drive `pad_pull_en` and `pad_pull_up` bit for bit, where select 1 means pull-up and 0 means pull-down.
- R5: Offsets 0x58, 0x5C and 0x60 hold bit 0, bit 1 and bit 2 of the drive code, one bit per pin. Pin n's code appears on `pad_drive[3n+2:3n]`. The code is milliamps/2 - 1.
- R6: With the type bit (0x0C) at 0 and the dual bit (0x10) at 0, pin n's raw status (0x1C) sets on a rising edge if its polarity bit (0x14) is 1, or on a falling edge if it is 0. The status sets on the third rising edge after the pad changes and stays set until it is cleared.
- R7: With the type bit at 0 and the dual bit at 1, both edges set the raw status.
- R8: With the type bit at 1, the raw status sets while the synchronised level equals the polarity bit. A clear written while the level is still active leaves it set. Once the level goes away, the bit stays latched until it is cleared.
- R9: Writing 1 to a bit of offset 0x24 clears that pin's raw status, and writing 0 has no effect. Offset 0x24 reads as zero. An event arriving in the same cycle as a clear leaves the bit set.
- R10: Offset 0x18 is the mask, where 1 enables a pin. Offset 0x20 reads raw status AND mask. Offset 0x1C shows the status regardless of the mask and ignores writes.
- R11: `irq` is the OR of the masked status bits, registered, so it follows a status or mask change one clock later.
- R12: Address bits [1:0] are ignored. Unmapped offsets read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 9 | Byte address within the bank |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pad_in | input | 32 | Raw pad levels, asynchronous |
| pad_out | output | 32 | Output value for each pad |
| pad_oe | output | 32 | Output enable for each pad |
| pad_pull_en | output | 32 | Pull resistor enable |
| pad_pull_up | output | 32 | Pull direction, 1 = up |
| pad_drive | output | 96 | Three-bit drive code per pin |
| irq | output | 1 | Registered OR of masked status |

## Verification
A stuck or mis-set configuration bit is visible right away on the pad-control outputs and in the register readback, within the cycle after the write. A faulty edge or level detector, or a lost previous sample, shows up in the raw status word three edges after a pad change. It shows up on `irq` one edge later again, so the bench samples at those exact cycles. A mistake in clear priority shows up only in the single cycle where a clear and an event meet, which the bench targets directly.

// File: rtl/gib_pkg.sv
package gib_pkg;
  localparam int DATA_W   = 32;
  localparam int DRV_BITS = 3;
  // byte offsets inside one bank; software decodes these
  localparam int OFF_DIN   = 'h00;
  localparam int OFF_DOUT  = 'h04;
  localparam int OFF_OE    = 'h08;
  localparam int OFF_TYPE  = 'h0C;
  localparam int OFF_DUAL  = 'h10;
  localparam int OFF_POL   = 'h14;
  localparam int OFF_MASK  = 'h18;
  localparam int OFF_RAW   = 'h1C;
  localparam int OFF_MSTAT = 'h20;
  localparam int OFF_CLR   = 'h24;
  localparam int OFF_PSEL  = 'h34;
  localparam int OFF_PEN   = 'h38;
  localparam int OFF_DRV0  = 'h58;
endpackage

// File: rtl/gib_sync.sv
module gib_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gib_detect.sv
module gib_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] cur,
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] dual,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] status
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] hit;
  logic [NPINS-1:0] status_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, edge_hit;
    assign rise     = cur[i] & ~prev_q[i];
    assign fall     = ~cur[i] & prev_q[i];
    assign edge_hit = dual[i] ? (rise | fall) : (pol[i] ? rise : fall);
    assign hit[i]   = lvl[i] ? (cur[i] == pol[i]) : edge_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= cur;
      // a new event outranks a clear in the same cycle
      status_q <= hit | (status_q & ~clr);
    end
  end

  assign status = status_q;
endmodule

// File: rtl/gib_bank.sv
module gib_bank
  import gib_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  input  logic [NPINS-1:0]          pad_in,
  output logic [NPINS-1:0]          pad_out,
  output logic [NPINS-1:0]          pad_oe,
  output logic [NPINS-1:0]          pad_pull_en,
  output logic [NPINS-1:0]          pad_pull_up,
  output logic [NPINS*DRV_BITS-1:0] pad_drive,
  output logic                      irq
);
  localparam int WA = ADDR_W - 2;

  logic [WA-1:0]    word;
  logic [1:0]       unused_lsb;
  logic [NPINS-1:0] wd;
  logic [NPINS-1:0] din_q, dout_q, oe_q, itype_q, dual_q, pol_q, mask_q;
  logic [NPINS-1:0] psel_q, pen_q, raw_st, clr_vec;
  logic [NPINS-1:0] drv_q [DRV_BITS];
  logic             irq_q;

  assign word       = addr[ADDR_W-1:2];
  assign unused_lsb = addr[1:0];
  assign wd         = wdata[NPINS-1:0];

  function automatic logic at(input logic [WA-1:0] w, input int off);
    return w == WA'(off / 4);
  endfunction

  gib_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(din_q)
  );

  assign clr_vec = (wr_en && at(word, OFF_CLR)) ? wd : '0;

  gib_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .cur(din_q), .lvl(itype_q), .dual(dual_q),
    .pol(pol_q), .clr(clr_vec), .status(raw_st)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      oe_q    <= '0;
      itype_q <= '0;
      dual_q  <= '0;
      pol_q   <= '0;
      mask_q  <= '0;
      psel_q  <= '0;
      pen_q   <= '0;
      for (int k = 0; k < DRV_BITS; k++) drv_q[k] <= '0;
    end else if (wr_en) begin
      if (at(word, OFF_DOUT)) dout_q  <= wd;
      if (at(word, OFF_OE))   oe_q    <= wd;
      if (at(word, OFF_TYPE)) itype_q <= wd;
      if (at(word, OFF_DUAL)) dual_q  <= wd;
      if (at(word, OFF_POL))  pol_q   <= wd;
      if (at(word, OFF_MASK)) mask_q  <= wd;
      if (at(word, OFF_PSEL)) psel_q  <= wd;
      if (at(word, OFF_PEN))  pen_q   <= wd;
      for (int k = 0; k < DRV_BITS; k++)
        if (at(word, OFF_DRV0 + 4 * k)) drv_q[k] <= wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(raw_st & mask_q);
  end

  always_comb begin
    rdata = '0;
    if (at(word, OFF_DIN))   rdata = DATA_W'(din_q);
    if (at(word, OFF_DOUT))  rdata = DATA_W'(dout_q);
    if (at(word, OFF_OE))    rdata = DATA_W'(oe_q);
    if (at(word, OFF_TYPE))  rdata = DATA_W'(itype_q);
    if (at(word, OFF_DUAL))  rdata = DATA_W'(dual_q);
    if (at(word, OFF_POL))   rdata = DATA_W'(pol_q);
    if (at(word, OFF_MASK))  rdata = DATA_W'(mask_q);
    if (at(word, OFF_RAW))   rdata = DATA_W'(raw_st);
    if (at(word, OFF_MSTAT)) rdata = DATA_W'(raw_st & mask_q);
    if (at(word, OFF_PSEL))  rdata = DATA_W'(psel_q);
    if (at(word, OFF_PEN))   rdata = DATA_W'(pen_q);
    for (int k = 0; k < DRV_BITS; k++)
      if (at(word, OFF_DRV0 + 4 * k)) rdata = DATA_W'(drv_q[k]);
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_drv
    for (genvar k = 0; k < DRV_BITS; k++) begin : g_bit
      assign pad_drive[p*DRV_BITS+k] = drv_q[k][p];
    end
  end

  assign pad_out     = dout_q;
  assign pad_oe      = oe_q;
  assign pad_pull_en = pen_q;
  assign pad_pull_up = psel_q;
  assign irq         = irq_q;
endmodule

// File: rtl/gib_checker.sv
module gib_checker
  import gib_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic [NPINS-1:0]  raw_st,
  input logic [NPINS-1:0]  mask_q,
  input logic [NPINS-1:0]  itype_q,
  input logic [NPINS-1:0]  clr_vec,
  input logic [NPINS-1:0]  din_q
);
  localparam int WA = ADDR_W - 2;

  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[ADDR_W-1:2] == WA'(OFF_CLR / 4)) |-> (rdata == '0)); // R9

  AST_MSTAT_IS_AND: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[ADDR_W-1:2] == WA'(OFF_MSTAT / 4)) |-> (rdata == DATA_W'(raw_st & mask_q))); // R10

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (($past(raw_st & ~clr_vec) & ~raw_st) == '0)); // R9

  AST_IRQ_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (irq == |($past(raw_st & mask_q)))); // R11

  AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((raw_st & ~$past(raw_st) & ~$past(itype_q)
               & ~($past(din_q) ^ $past(din_q, 2))) == '0)); // R6
endmodule

bind gib_bank gib_checker #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_gib_checker (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rdata(rdata), .irq(irq),
  .raw_st(raw_st), .mask_q(mask_q), .itype_q(itype_q), .clr_vec(clr_vec),
  .din_q(din_q)
);

// File: tb/test_gib_bank.sv
module test_gib_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, wr_en;
  logic [8:0]  addr;
  logic [31:0] wdata, rdata, pad_in, pad_out, pad_oe, pad_pull_en, pad_pull_up;
  logic [95:0] pad_drive;
  logic        irq;
  int          total = 0;
  int          fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gib_bank i_gib_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up),
    .pad_drive(pad_drive), .irq(irq)
  );

  typedef struct packed {
    logic [8:0]  waddr;
    logic [31:0] wval;
    logic [8:0]  raddr;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{9'h004, 32'hA5A5_0F0F, 9'h004, 32'hA5A5_0F0F, 4'd2},  // R2
    '{9'h008, 32'hFFFF_0000, 9'h008, 32'hFFFF_0000, 4'd2},  // R2
    '{9'h034, 32'h1234_5678, 9'h034, 32'h1234_5678, 4'd4},  // R4
    '{9'h038, 32'h8765_4321, 9'h038, 32'h8765_4321, 4'd4},  // R4
    '{9'h058, 32'h0000_00FF, 9'h058, 32'h0000_00FF, 4'd5},  // R5
    '{9'h05C, 32'h0000_FF00, 9'h05C, 32'h0000_FF00, 4'd5},  // R5
    '{9'h060, 32'h00FF_0000, 9'h060, 32'h00FF_0000, 4'd5},  // R5
    '{9'h000, 32'hFFFF_FFFF, 9'h000, 32'h0000_0000, 4'd3},  // R3 write ignored
    '{9'h024, 32'hFFFF_FFFF, 9'h024, 32'h0000_0000, 4'd9},  // R9 reads zero
    '{9'h040, 32'hFFFF_FFFF, 9'h040, 32'h0000_0000, 4'd12}, // R12 unmapped
    '{9'h00B, 32'hC3C3_C3C3, 9'h008, 32'hC3C3_C3C3, 4'd12}, // R12 low bits ignored
    '{9'h01C, 32'hFFFF_FFFF, 9'h01C, 32'h0000_0000, 4'd10}  // R10 status read-only
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; total++;
    $display("FAIL watchdog all-requirements got=hung exp=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; pad_in = '0;
    step(3);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    rd(9'h008, r); chk("R1 oe reg", r, 32'h0);
    rd(9'h018, r); chk("R1 mask reg", r, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pull_en", pad_pull_en, 32'h0);
    chk("R1 drive", pad_drive[31:0] | pad_drive[63:32] | pad_drive[95:64], 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // register table walk
    foreach (VECS[i]) begin
      wr(VECS[i].waddr, VECS[i].wval);
      rd(VECS[i].raddr, r);
      chk($sformatf("R%0d table[%0d]", VECS[i].req, i), r, VECS[i].exp);
    end
    chk("R2 pad_out", pad_out, 32'hA5A5_0F0F);
    chk("R2 pad_oe", pad_oe, 32'hC3C3_C3C3);
    chk("R4 pad_pull_up", pad_pull_up, 32'h1234_5678);
    chk("R4 pad_pull_en", pad_pull_en, 32'h8765_4321);
    chk("R5 pin0 code", {29'h0, pad_drive[2:0]}, 32'd1);
    chk("R5 pin8 code", {29'h0, pad_drive[26:24]}, 32'd2);
    chk("R5 pin16 code", {29'h0, pad_drive[50:48]}, 32'd4);
    chk("R5 pin31 code", {29'h0, pad_drive[95:93]}, 32'd0);

    // R3 data in through synchroniser
    pad_in[9] = 1'b1;
    step(1); rd(9'h000, r); chk("R3 din after one edge", r, 32'h0);
    step(1); rd(9'h000, r); chk("R3 din after two edges", r, 32'h200);
    pad_in[9] = 1'b0;
    step(3);
    wr(9'h024, 32'hFFFF_FFFF);

    // R6 rising edge on pin 0
    wr(9'h014, 32'h1);
    pad_in[0] = 1'b1; step(2);
    rd(9'h01C, r); chk("R6 not yet set", r, 32'h0);
    step(1); rd(9'h01C, r); chk("R6 rising sets", r, 32'h1);
    wr(9'h024, 32'h0); rd(9'h01C, r); chk("R9 zero write no effect", r, 32'h1);
    wr(9'h024, 32'h1); rd(9'h01C, r); chk("R9 one clears", r, 32'h0);
    pad_in[0] = 1'b0; step(3);
    rd(9'h01C, r); chk("R6 falling ignored in rising mode", r, 32'h0);

    // R6 falling edge on pin 1
    pad_in[1] = 1'b1; step(3);
    rd(9'h01C, r); chk("R6 rising ignored in falling mode", r, 32'h0);
    pad_in[1] = 1'b0; step(3);
    rd(9'h01C, r); chk("R6 falling sets", r, 32'h2);
    wr(9'h024, 32'h2);

    // R7 dual edge on pin 2
    wr(9'h010, 32'h4);
    pad_in[2] = 1'b1; step(3);
    rd(9'h01C, r); chk("R7 rise sets", r, 32'h4);
    wr(9'h024, 32'h4);
    pad_in[2] = 1'b0; step(3);
    rd(9'h01C, r); chk("R7 fall sets", r, 32'h4);
    wr(9'h024, 32'h4);

    // R8 level high on pin 3
    wr(9'h014, 32'h9);
    wr(9'h00C, 32'h8);
    step(1); rd(9'h01C, r); chk("R8 inactive level", r, 32'h0);
    pad_in[3] = 1'b1; step(3);
    rd(9'h01C, r); chk("R8 level sets", r, 32'h8);
    wr(9'h024, 32'h8); rd(9'h01C, r); chk("R8 clear while active", r, 32'h8);
    pad_in[3] = 1'b0; step(3);
    rd(9'h01C, r); chk("R8 latched after level gone", r, 32'h8);
    wr(9'h024, 32'h8); rd(9'h01C, r); chk("R8 clear after level gone", r, 32'h0);
    // R8 level low on pin 4 (pad already low)
    wr(9'h00C, 32'h18);
    step(1); rd(9'h01C, r); chk("R8 active-low level", r, 32'h10);
    wr(9'h00C, 32'h0);
    wr(9'h024, 32'h10); rd(9'h01C, r); chk("R8 cleared after edge mode", r, 32'h0);

    // R10 / R11 mask and irq on pin 0 (rising)
    wr(9'h018, 32'h1);
    pad_in[0] = 1'b1; step(3);
    rd(9'h020, r); chk("R10 masked status", r, 32'h1);
    chk("R11 irq not yet", {31'h0, irq}, 32'h0);
    step(1); chk("R11 irq raised", {31'h0, irq}, 32'h1);
    wr(9'h018, 32'h0);
    chk("R11 irq one cycle late", {31'h0, irq}, 32'h1);
    rd(9'h020, r); chk("R10 masked reads zero", r, 32'h0);
    step(1); chk("R11 irq dropped", {31'h0, irq}, 32'h0);
    rd(9'h01C, r); chk("R10 raw ignores mask", r, 32'h1);
    wr(9'h024, 32'h1);

    // R9 edge and clear in the same cycle
    pad_in[0] = 1'b0; step(3);
    pad_in[0] = 1'b1; step(2);
    wr(9'h024, 32'h1);
    rd(9'h01C, r); chk("R9 event beats clear", r, 32'h1);

    // R1 reset mid-run
    rst_n = 1'b0; step(1); rst_n = 1'b1; #1;
    rd(9'h01C, r); chk("R1 status after reset", r, 32'h0);
    rd(9'h004, r); chk("R1 dout after reset", r, 32'h0);
    chk("R1 pad_oe after reset", pad_oe, 32'h0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule